// File: doc/BRIEF.md
# Entropy Source Bias Servo

This block closes a slow control loop around a stochastic bit source. It reads a serial stream of raw random bits, each marked by a valid strobe, and counts the ones over a fixed window of valid bits. When the window closes, it compares the ones count with a deadband centred on half the window. A count outside the deadband moves a 12-bit drive-amplitude code by a single LSB. That code sets the write-pulse amplitude of the device, so the ones fraction is pulled back toward one half.

Each new code is handed to an external serial-bus master as a one-cycle request with the code attached. That master writes the code to the DAC. While the master reports busy, the request waits and the code is frozen. A polarity input selects which way the code moves for a given bias. An enable input freezes the code while window counting goes on.

The defaults are a window of 1,000,000 bits with limits at 495,000 and 505,000 ones. At a raw rate of about 10.6 MHz, one window lasts roughly a tenth of a second. Every size is a parameter.

Top module: `drive_bias_servo`

## Requirements
- R1: A window closes on the WIN_LEN-th valid bit after reset or after the previous window closed. That closing bit is counted in the window, and both the bit count and the ones count start again from zero for the next bit.
- R2: A window whose ones count is less than LOW_LIM or greater than HIGH_LIM triggers a correction. A count equal to either limit, or between them, leaves the code unchanged.
- R3: With step_polarity = 0, a count above HIGH_LIM decrements the code and a count below LOW_LIM increments it. With step_polarity = 1 both directions are reversed.
- R4: A correction changes the code by exactly one LSB, and at most one correction is applied per window, however large the bias.
- R5: The code saturates: an increment at 4095 and a decrement at 0 leave it unchanged and raise no request.
- R6: Each code change raises upd_req for exactly one cycle, with upd_code equal to the new code. When i2c_busy is low, upd_req is high in the third cycle after the clock edge that takes the closing bit. A window that leaves the code unchanged raises no request.
- R7: While i2c_busy is high, upd_req stays low and the updated code waits. Windows that close while a request is outstanding make no correction. The request is raised in the cycle after the first edge that samples i2c_busy low.
- R8: A synchronous active-high reset loads init_code into the code, drops upd_req and discards any partly counted window.
- R9: While enable is low, window results cause no correction and no request, but windows keep being counted so that their alignment is kept.
- R10: bit_in is ignored in cycles where bit_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_code | input | CODE_W | Code loaded by reset |
| bit_valid | input | 1 | bit_in carries a sample this cycle |
| bit_in | input | 1 | Raw random bit |
| step_polarity | input | 1 | 0: excess ones lowers the code; 1: excess ones raises it |
| enable | input | 1 | Allows corrections when high |
| i2c_busy | input | 1 | External bus master cannot take a request |
| code_out | output | CODE_W | Current drive code |
| upd_req | output | 1 | One-cycle update request |
| upd_code | output | CODE_W | Code carried with the request |

## Verification
A wrong ones or bit counter shows up as a window that closes one bit early or late. The next boundary window then moves the code when it should not, or fails to move it. This is visible at code_out about three cycles after the closing bit. A wrong direction or saturation decision shows up as a code value off by one, or wrapped, at the same point. A stuck pending flag shows up as a missing request, or an extra one, on the first non-busy cycle. A lost reset of the window shows up as a correction in the first window after reset when none is due.

// File: rtl/bias_servo_pkg.sv
package bias_servo_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/bias_window_counter.sv
module bias_window_counter #(
  parameter int WIN_LEN = 1_000_000,
  parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic             win_done,
  output logic [CNT_W-1:0] win_ones
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_LEN - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] ones_cnt;
  logic [CNT_W-1:0] ones_next;

  assign ones_next = ones_cnt + CNT_W'(bit_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      ones_cnt <= '0;
      win_done <= 1'b0;
      win_ones <= '0;
    end else begin
      win_done <= 1'b0;
      if (bit_valid) begin
        if (bit_cnt == LAST) begin
          win_done <= 1'b1;
          win_ones <= ones_next;
          bit_cnt  <= '0;
          ones_cnt <= '0;
        end else begin
          bit_cnt  <= bit_cnt + 1'b1;
          ones_cnt <= ones_next;
        end
      end
    end
  end
endmodule

// File: rtl/bias_step_decider.sv
module bias_step_decider
  import bias_servo_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int LOW_LIM  = 495_000,
  parameter int HIGH_LIM = 505_000
) (
  input  logic [CNT_W-1:0] win_ones,
  input  logic             step_polarity,
  output step_e            step
);
  localparam logic [CNT_W-1:0] LO = CNT_W'(LOW_LIM);
  localparam logic [CNT_W-1:0] HI = CNT_W'(HIGH_LIM);

  always_comb begin
    step = STEP_NONE;
    if (win_ones > HI) begin
      step = step_polarity ? STEP_UP : STEP_DOWN;
    end else if (win_ones < LO) begin
      step = step_polarity ? STEP_DOWN : STEP_UP;
    end
  end
endmodule

// File: rtl/bias_code_register.sv
module bias_code_register
  import bias_servo_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] init_code,
  input  logic              win_done,
  input  step_e             step,
  input  logic              enable,
  input  logic              i2c_busy,
  output logic [CODE_W-1:0] code,
  output logic              upd_req,
  output logic [CODE_W-1:0] upd_code
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic              pend;
  logic [CODE_W-1:0] code_nxt;

  always_comb begin
    code_nxt = code;
    unique case (step)
      STEP_UP:   if (code != CODE_MAX) code_nxt = code + 1'b1;
      STEP_DOWN: if (code != '0)       code_nxt = code - 1'b1;
      default:   code_nxt = code;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code     <= init_code;
      upd_code <= init_code;
      upd_req  <= 1'b0;
      pend     <= 1'b0;
    end else begin
      upd_req <= 1'b0;
      if (pend) begin
        if (!i2c_busy) begin
          upd_req  <= 1'b1;
          upd_code <= code;
          pend     <= 1'b0;
        end
      end else if (win_done && enable && (code_nxt != code)) begin
        code <= code_nxt;
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/drive_bias_servo.sv
module drive_bias_servo
  import bias_servo_pkg::*;
#(
  parameter int WIN_LEN  = 1_000_000,
  parameter int LOW_LIM  = 495_000,
  parameter int HIGH_LIM = 505_000,
  parameter int CODE_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] init_code,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              step_polarity,
  input  logic              enable,
  input  logic              i2c_busy,
  output logic [CODE_W-1:0] code_out,
  output logic              upd_req,
  output logic [CODE_W-1:0] upd_code
);
  localparam int CNT_W = $clog2(WIN_LEN + 1);

  logic             win_done;
  logic [CNT_W-1:0] win_ones;
  step_e            step;

  bias_window_counter #(
    .WIN_LEN(WIN_LEN),
    .CNT_W  (CNT_W)
  ) u_window (
    .clk      (clk),
    .rst      (rst),
    .bit_valid(bit_valid),
    .bit_in   (bit_in),
    .win_done (win_done),
    .win_ones (win_ones)
  );

  bias_step_decider #(
    .CNT_W   (CNT_W),
    .LOW_LIM (LOW_LIM),
    .HIGH_LIM(HIGH_LIM)
  ) u_decide (
    .win_ones     (win_ones),
    .step_polarity(step_polarity),
    .step         (step)
  );

  bias_code_register #(
    .CODE_W(CODE_W)
  ) u_code (
    .clk      (clk),
    .rst      (rst),
    .init_code(init_code),
    .win_done (win_done),
    .step     (step),
    .enable   (enable),
    .i2c_busy (i2c_busy),
    .code     (code_out),
    .upd_req  (upd_req),
    .upd_code (upd_code)
  );
endmodule

// File: rtl/drive_bias_servo_checker.sv
module drive_bias_servo_checker #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              i2c_busy,
  input logic [CODE_W-1:0] code_out,
  input logic              upd_req,
  input logic [CODE_W-1:0] upd_code
);
  logic was_rst;
  always_ff @(posedge clk) was_rst <= rst;

  AST_ONE_LSB: assert property (@(posedge clk) disable iff (rst)
    (!was_rst && code_out != $past(code_out)) |->
      (({1'b0, code_out} == {1'b0, $past(code_out)} + 1'b1) ||
       ({1'b0, $past(code_out)} == {1'b0, code_out} + 1'b1))); // R4

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    upd_req |=> !upd_req); // R6

  AST_REQ_CODE: assert property (@(posedge clk) disable iff (rst)
    upd_req |-> (upd_code == code_out)); // R6

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (upd_req && !was_rst) |-> !$past(i2c_busy)); // R7

  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!was_rst && code_out != $past(code_out)) |-> $past(enable)); // R9
endmodule

bind drive_bias_servo drive_bias_servo_checker #(.CODE_W(CODE_W)) u_checker (
  .clk     (clk),
  .rst     (rst),
  .enable  (enable),
  .i2c_busy(i2c_busy),
  .code_out(code_out),
  .upd_req (upd_req),
  .upd_code(upd_code)
);

// File: tb/test_drive_bias_servo.sv
module test_drive_bias_servo;
  localparam int WIN = 40;
  localparam int LO  = 18;
  localparam int HI  = 22;
  localparam int CW  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] init_code = 12'd2048;
  logic          bit_valid = 1'b0;
  logic          bit_in = 1'b0;
  logic          step_polarity = 1'b0;
  logic          enable = 1'b1;
  logic          i2c_busy = 1'b0;
  logic [CW-1:0] code_out;
  logic          upd_req;
  logic [CW-1:0] upd_code;

  int checks = 0;
  int failures = 0;
  int req_seen = 0;
  int last_upd = 0;
  int exp_code = 0;
  int exp_reqs = 0;

  always #2 clk = ~clk;

  drive_bias_servo #(
    .WIN_LEN(WIN), .LOW_LIM(LO), .HIGH_LIM(HI), .CODE_W(CW)
  ) i_drive_bias_servo (
    .clk(clk), .rst(rst), .init_code(init_code), .bit_valid(bit_valid),
    .bit_in(bit_in), .step_polarity(step_polarity), .enable(enable),
    .i2c_busy(i2c_busy), .code_out(code_out), .upd_req(upd_req),
    .upd_code(upd_code)
  );

  always @(negedge clk) begin
    if (upd_req) begin
      req_seen <= req_seen + 1;
      last_upd <= int'(upd_code);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(int c, int k, bit pol, bit en);
    int d;
    int n;
    d = 0;
    if (en) begin
      if (k > HI) d = pol ? 1 : -1;
      else if (k < LO) d = pol ? -1 : 1;
    end
    n = c + d;
    if (n < 0) n = 0;
    if (n > 4095) n = 4095;
    return n;
  endfunction

  task automatic send_bit(input bit b);
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in = b;
    if (($urandom % 4) == 0) begin
      @(negedge clk);
      bit_valid = 1'b0;
      bit_in = 1'b1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = 1'b0;
      bit_in = $urandom % 2;
    end
  endtask

  task automatic send_window(input int k);
    int rem;
    rem = k;
    for (int i = 0; i < WIN; i++) begin
      if (int'($urandom % (WIN - i)) < rem) begin
        send_bit(1'b1);
        rem--;
      end else begin
        send_bit(1'b0);
      end
    end
  endtask

  task automatic do_reset(input int init);
    @(negedge clk);
    rst = 1'b1;
    init_code = CW'(init);
    bit_valid = 1'b0;
    idle(2);
    rst = 1'b0;
    exp_code = init;
  endtask

  task automatic window_check(input int k, input string req);
    int n;
    n = model(exp_code, k, step_polarity, enable);
    send_window(k);
    idle(6);
    if (n != exp_code) exp_reqs++;
    chk(int'(code_out) == n, req, int'(code_out), n);
    chk(req_seen == exp_reqs, req, req_seen, exp_reqs);
    if (n != exp_code) chk(last_upd == n, req, last_upd, n);
    exp_code = n;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    do_reset(2048);
    idle(1);
    chk(int'(code_out) == 2048, "R8 reset code", int'(code_out), 2048);
    chk(upd_req == 1'b0, "R8 reset req", int'(upd_req), 0);

    // R2 limits and deadband, R3 directions, R4 single step, R10 gaps
    window_check(LO, "R2 low limit");
    window_check(HI, "R2 high limit");
    window_check(20, "R2 centre");
    window_check(LO - 1, "R2 R3 below");
    window_check(HI + 1, "R2 R3 above");
    window_check(0, "R4 all zeros");
    window_check(WIN, "R4 all ones");
    step_polarity = 1'b1;
    window_check(30, "R3 pol high");
    window_check(5, "R3 pol low");
    step_polarity = 1'b0;

    // R6 request timing: third cycle after the closing edge
    begin
      int base;
      base = req_seen;
      for (int i = 0; i < WIN - 1; i++) send_bit(1'b0);
      @(negedge clk); bit_valid = 1'b1; bit_in = 1'b0;
      @(negedge clk); bit_valid = 1'b0;
      chk(upd_req == 1'b0, "R6 timing c1", int'(upd_req), 0);
      @(negedge clk);
      chk(upd_req == 1'b0, "R6 timing c2", int'(upd_req), 0);
      @(negedge clk);
      chk(upd_req == 1'b1, "R6 timing c3", int'(upd_req), 1);
      @(negedge clk);
      chk(upd_req == 1'b0, "R6 one cycle", int'(upd_req), 0);
      exp_code = model(exp_code, 0, 1'b0, 1'b1);
      exp_reqs++;
      idle(3);
      chk(req_seen == base + 1, "R6 single req", req_seen, base + 1);
    end

    // R1 closing bit counted and alignment
    for (int i = 0; i < WIN - 1; i++) send_bit(i < HI);
    idle(6);
    chk(int'(code_out) == exp_code, "R1 window not closed", int'(code_out), exp_code);
    @(negedge clk); bit_valid = 1'b1; bit_in = 1'b1;
    idle(6);
    exp_code = model(exp_code, HI + 1, 1'b0, 1'b1);
    exp_reqs++;
    chk(int'(code_out) == exp_code, "R1 closing bit", int'(code_out), exp_code);

    // R9 enable low
    enable = 1'b0;
    window_check(0, "R9 frozen");
    enable = 1'b1;
    window_check(20, "R9 alignment");
    window_check(0, "R9 resumed");

    // R7 busy
    i2c_busy = 1'b1;
    send_window(0);
    idle(6);
    exp_code = model(exp_code, 0, 1'b0, 1'b1);
    chk(int'(code_out) == exp_code, "R7 code updated", int'(code_out), exp_code);
    chk(req_seen == exp_reqs, "R7 no req busy", req_seen, exp_reqs);
    send_window(0);
    idle(6);
    chk(int'(code_out) == exp_code, "R7 held pending", int'(code_out), exp_code);
    @(negedge clk); i2c_busy = 1'b0;
    @(negedge clk);
    chk(upd_req == 1'b1, "R7 req after release", int'(upd_req), 1);
    exp_reqs++;
    idle(3);
    chk(last_upd == exp_code, "R7 req code", last_upd, exp_code);
    chk(req_seen == exp_reqs, "R7 req count", req_seen, exp_reqs);

    // R5 saturation
    do_reset(4095);
    window_check(0, "R5 top");
    do_reset(0);
    window_check(WIN, "R5 bottom");
    window_check(0, "R5 leave bottom");

    // R8 reset discards partial window
    for (int i = 0; i < 30; i++) send_bit(1'b1);
    do_reset(100);
    window_check(20, "R8 fresh window");
    chk(int'(code_out) == 100, "R8 init code", int'(code_out), 100);

    // random windows
    for (int w = 0; w < 40; w++) begin
      step_polarity = $urandom % 2;
      enable = ($urandom % 5) != 0;
      if (($urandom % 3) == 0) window_check(LO - 1 + int'($urandom % 6), "R2 random edge");
      else window_check(int'($urandom % (WIN + 1)), "R3 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule